// File: doc/BRIEF.md
# Dual-Ring Descriptor Copy Engine

This block copies memory to memory from work that software posts in two parallel descriptor rings. The two rings share one slot index. For each slot, the source ring gives the read address, the byte length and a last-segment marker. The destination ring gives the write address and receives a completion word once the slot is done. Software writes ring bases and slot counts, then posts work by moving the transmit-side CPU index forward. The engine walks slots from its own DMA index until that index meets the CPU index.

Each slot is handled as a fixed sequence of single 32-bit memory transactions:
- read the source pointer;
- read the length word;
- read the destination pointer;
- read and write each data word in turn;
- optionally write back a completion word.

Only one transaction is ever outstanding. A request is held until the memory accepts it, and the engine waits for its response before issuing the next.

Top module: `desc_copy_engine`

## Requirements
- R1: After reset the slot counts of both rings read 64, the DMA indices and the transmit CPU index read 0, the receive CPU index reads 63 (count - 1), the global register (0x204) reads 0, and no memory request is issued.
- R2: While transmit-enable (global bit 0) and receive-enable (global bit 2) are both set and the transmit DMA index (0x00C) differs from the transmit CPU index (0x008), the engine processes the slot at the DMA index. It then advances both DMA indices (0x00C, 0x10C) by one.
- R3: A slot copies length/4 words in order from the source pointer (word 0 of the TX descriptor at base + 16*slot) to the destination pointer (word 0 of the RX descriptor). Memory past the length is not written.
- R4: With write-back enabled (global bit 6), the engine writes word 1 of the RX descriptor after the data. That word holds the TX length field at bits 29:16, the done flag at bit 31 and the last-segment bit copied from TX word 1 bit 30. With bit 6 clear, RX word 1 is left untouched.
- R5: A length field above 0x3F80 moves only 0x3F80 bytes, and the written-back length is the original field. A length of zero moves no data and still completes the slot.
- R6: While a slot runs, the busy bits (global bits 1 and 3) read 1. Clearing the enables lets that slot finish, including its write-back, and busy then drops. No further slot starts until the enables are set again.
- R7: Writing the reset register (0x208) with bit 0 set clears the transmit DMA index only. Writing it with bit 16 set clears the receive DMA index only.
- R8: At most one memory transaction is outstanding: no request is raised while a response is due. A request that is not accepted keeps its address and direction on the next cycle.
- R9: Slot counts are writable powers of two. DMA indices wrap to 0 after count - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqWrite | output | 1 | 1 for a write, 0 for a read |
| memReqAddr | output | 32 | Byte address of the word |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Response (read data or write acknowledge) valid |
| memRspData | input | 32 | Read data |

## Verification
Register reads are combinational, so the bench samples them one time step after it sets the address at a falling edge. The DMA indices move on the clock edge that takes the last response of a slot, which is the write-back response when write-back is on. The number of cycles a slot takes depends on the memory's ready pattern. The bench therefore polls the DMA index once per cycle and inspects memory only after the index has moved, so every data word and the completion word are already final. The busy bits are read while a long slot is still running, and again after they fall, before the bench checks that no new slot has started.

// File: rtl/dcopy_pkg.sv
package dcopy_pkg;
  localparam logic [13:0] MAX_SEG_BYTES = 14'h3F80;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SRCPTR, PH_LEN, PH_DSTPTR, PH_RDDATA, PH_WRDATA, PH_WBACK
  } phaseT;

  typedef struct packed {
    phaseT phase;
    logic  startSlot;
    logic  ldSrc;
    logic  ldLen;
    logic  ldDst;
    logic  ldData;
    logic  stepWord;
    logic  advance;
  } strobeT;
endpackage

// File: rtl/dce_ctrl.sv
module dce_ctrl
  import dcopy_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   goSlot,
  input  logic   nWordsZero,
  input  logic   lastWord,
  input  logic   wbEn,
  input  logic   memReqReady,
  input  logic   memRspValid,
  output logic   memReqValid,
  output logic   busy,
  output strobeT stb
);
  phaseT phase, nextPhase;
  logic  waiting, rspDone;

  assign rspDone = waiting && memRspValid;

  always_comb begin
    nextPhase = PH_IDLE;
    case (phase)
      PH_SRCPTR: nextPhase = PH_LEN;
      PH_LEN:    nextPhase = PH_DSTPTR;
      PH_DSTPTR: nextPhase = nWordsZero ? (wbEn ? PH_WBACK : PH_IDLE) : PH_RDDATA;
      PH_RDDATA: nextPhase = PH_WRDATA;
      PH_WRDATA: nextPhase = lastWord ? (wbEn ? PH_WBACK : PH_IDLE) : PH_RDDATA;
      default:   nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      waiting <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (goSlot) phase <= PH_SRCPTR;
    end else if (!waiting) begin
      if (memReqReady) waiting <= 1'b1;
    end else if (memRspValid) begin
      waiting <= 1'b0;
      phase   <= nextPhase;
    end
  end

  always_comb begin
    stb.phase     = phase;
    stb.startSlot = (phase == PH_IDLE) && goSlot;
    stb.ldSrc     = rspDone && (phase == PH_SRCPTR);
    stb.ldLen     = rspDone && (phase == PH_LEN);
    stb.ldDst     = rspDone && (phase == PH_DSTPTR);
    stb.ldData    = rspDone && (phase == PH_RDDATA);
    stb.stepWord  = rspDone && (phase == PH_WRDATA);
    stb.advance   = rspDone && (nextPhase == PH_IDLE);
  end

  assign memReqValid = (phase != PH_IDLE) && !waiting;
  assign busy        = (phase != PH_IDLE);
endmodule

// File: rtl/dce_datapath.sv
module dce_datapath
  import dcopy_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 16,
  parameter int SLOTS    = 64,
  parameter int DONE_POS = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  strobeT            stb,
  input  logic              busy,
  input  logic [31:0]       memRspData,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [31:0]       memReqWdata,
  output logic              goSlot,
  output logic              nWordsZero,
  output logic              lastWord,
  output logic              wbEn
);
  localparam int          LAST_POS = DONE_POS - 1;
  localparam logic [11:0] GLB_ADDR = 12'h204;
  localparam logic [11:0] RST_ADDR = 12'h208;

  logic txEn, rxEn;

  for (genvar r = 0; r < 2; r++) begin : g_ring
    localparam logic [11:0] OFS = 12'(r * 256);
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  count, cpu, dma, idxMask;
    logic [31:0]       rdVal;

    assign idxMask = count - IDX_W'(1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        base  <= '0;
        count <= IDX_W'(SLOTS);
        cpu   <= (r == 1) ? IDX_W'(SLOTS - 1) : '0;
        dma   <= '0;
      end else begin
        if (regWe && regAddr == OFS)           base  <= regWdata[ADDR_W-1:0];
        if (regWe && regAddr == OFS + 12'h4)   count <= regWdata[IDX_W-1:0];
        if (regWe && regAddr == OFS + 12'h8)   cpu   <= regWdata[IDX_W-1:0];
        if (regWe && regAddr == RST_ADDR && regWdata[r*16]) dma <= '0;
        else if (stb.advance)                  dma <= (dma + IDX_W'(1)) & idxMask;
        else if (regWe && regAddr == OFS + 12'hC) dma <= regWdata[IDX_W-1:0];
      end
    end

    always_comb begin
      rdVal = '0;
      if (regAddr == OFS)          rdVal = 32'(base);
      if (regAddr == OFS + 12'h4)  rdVal = 32'(count);
      if (regAddr == OFS + 12'h8)  rdVal = 32'(cpu);
      if (regAddr == OFS + 12'hC)  rdVal = 32'(dma);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
      wbEn <= 1'b0;
    end else if (regWe && regAddr == GLB_ADDR) begin
      txEn <= regWdata[0];
      rxEn <= regWdata[2];
      wbEn <= regWdata[6];
    end
  end

  always_comb begin
    regRdata = g_ring[0].rdVal | g_ring[1].rdVal;
    if (regAddr == GLB_ADDR) regRdata = {25'd0, wbEn, 2'b00, busy, rxEn, busy, txEn};
  end

  assign goSlot = txEn && rxEn && (g_ring[0].dma != g_ring[0].cpu);

  // per-slot working registers
  logic [ADDR_W-1:0] srcPtr, dstPtr;
  logic [13:0]       lenRaw, lenClamp;
  logic              lastSeg;
  logic [31:0]       dataReg, wbWord;
  logic [11:0]       wordIdx, nWords;

  assign lenClamp   = (lenRaw > MAX_SEG_BYTES) ? MAX_SEG_BYTES : lenRaw;
  assign nWords     = lenClamp[13:2];
  assign nWordsZero = (nWords == '0);
  assign lastWord   = (wordIdx == nWords - 12'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtr  <= '0;
      dstPtr  <= '0;
      lenRaw  <= '0;
      lastSeg <= 1'b0;
      dataReg <= '0;
      wordIdx <= '0;
    end else begin
      if (stb.ldSrc)    srcPtr  <= memRspData[ADDR_W-1:0];
      if (stb.ldDst)    dstPtr  <= memRspData[ADDR_W-1:0];
      if (stb.ldLen) begin
        lenRaw  <= memRspData[29:16];
        lastSeg <= memRspData[LAST_POS];
      end
      if (stb.ldData)   dataReg <= memRspData;
      if (stb.startSlot)     wordIdx <= '0;
      else if (stb.stepWord) wordIdx <= wordIdx + 12'd1;
    end
  end

  logic [ADDR_W-1:0] descOfs, wordOfs;
  assign descOfs = ADDR_W'({g_ring[0].dma, 4'b0000});
  assign wordOfs = ADDR_W'({wordIdx, 2'b00});
  assign wbWord  = (32'(lenRaw) << 16) | (32'd1 << DONE_POS) | (32'(lastSeg) << LAST_POS);

  always_comb begin
    memReqAddr = '0;
    case (stb.phase)
      PH_SRCPTR: memReqAddr = g_ring[0].base + descOfs;
      PH_LEN:    memReqAddr = g_ring[0].base + descOfs + ADDR_W'(4);
      PH_DSTPTR: memReqAddr = g_ring[1].base + descOfs;
      PH_RDDATA: memReqAddr = srcPtr + wordOfs;
      PH_WRDATA: memReqAddr = dstPtr + wordOfs;
      PH_WBACK:  memReqAddr = g_ring[1].base + descOfs + ADDR_W'(4);
      default:   memReqAddr = '0;
    endcase
  end

  assign memReqWrite = (stb.phase == PH_WRDATA) || (stb.phase == PH_WBACK);
  assign memReqWdata = (stb.phase == PH_WBACK) ? wbWord : dataReg;
endmodule

// File: rtl/desc_copy_engine.sv
module desc_copy_engine
  import dcopy_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 16,
  parameter int SLOTS       = 64,
  parameter bit DONE_AT_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [31:0]       memReqWdata,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData
);
  localparam int DONE_POS = DONE_AT_TOP ? 31 : 15;

  strobeT stb;
  logic   engBusy, goSlot, nWordsZero, lastWord, wbEn;
  logic [31:0] doneMask;
  assign doneMask = 32'd1 << DONE_POS;

  dce_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .goSlot(goSlot), .nWordsZero(nWordsZero),
    .lastWord(lastWord), .wbEn(wbEn), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memReqValid(memReqValid), .busy(engBusy), .stb(stb)
  );

  dce_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOTS(SLOTS), .DONE_POS(DONE_POS)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .stb(stb), .busy(engBusy), .memRspData(memRspData),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .goSlot(goSlot), .nWordsZero(nWordsZero), .lastWord(lastWord), .wbEn(wbEn)
  );
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [31:0]       memReqWdata,
  input logic              memRspValid,
  input logic              busy,
  input logic              goSlot,
  input logic              inWb,
  input logic [31:0]       doneMask
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  assert_rsp_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> !memReqValid);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(goSlot));

  assert_start_prompt_R2: assert property (@(posedge clk) disable iff (!rstN)
    goSlot && !busy |=> busy);

  assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && inWb |-> memReqWrite && ((memReqWdata & doneMask) != 32'd0));
endmodule

bind desc_copy_engine dce_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
  .memRspValid(memRspValid), .busy(engBusy), .goSlot(goSlot),
  .inWb(stb.phase == dcopy_pkg::PH_WBACK), .doneMask(doneMask)
);

// File: tb/desc_copy_engine_bench.sv
module desc_copy_engine_bench;
  localparam int MEM_WORDS = 1024;
  localparam logic [31:0] SRC_PAT = 32'hC0DE0000;
  // table: {src byte addr, dst byte addr, length bytes, last-segment flag}
  localparam logic [63:0] VEC [4] = '{
    64'h0800_0C00_0010_0001, 64'h0840_0C40_0004_0000,
    64'h0880_0C80_0000_0001, 64'h08C0_0CC0_0028_0001
  };

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic regWe; logic [11:0] regAddr; logic [31:0] regWdata, regRdata;
  logic memReqValid, memReqReady, memReqWrite, memRspValid = 1'b0;
  logic [31:0] memReqAddr, memReqWdata, memRspData = '0;

  int checks = 0, fails = 0, protoErr = 0, writeCount = 0;
  logic [31:0] mem [MEM_WORDS];
  logic bdWe = 1'b0; logic [9:0] bdIdx = '0; logic [31:0] bdData = '0;
  logic [1:0] rdyCnt = '0;
  logic holdPend = 1'b0; logic [31:0] holdAddr = '0;

  desc_copy_engine u_desc_copy_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  assign memReqReady = (rdyCnt != 2'd2);

  always @(posedge clk) begin
    rdyCnt <= (rdyCnt == 2'd2) ? 2'd0 : rdyCnt + 2'd1;
    memRspValid <= 1'b0;
    if (bdWe) mem[bdIdx] <= bdData;
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      if (memReqWrite) begin
        mem[memReqAddr[11:2]] <= memReqWdata;
        writeCount <= writeCount + 1;
      end else memRspData <= mem[memReqAddr[11:2]];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (memRspValid && memReqValid) protoErr <= protoErr + 1;
      if (holdPend && (!memReqValid || memReqAddr != holdAddr)) protoErr <= protoErr + 1;
    end
    holdPend <= memReqValid && !memReqReady;
    holdAddr <= memReqAddr;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic memWr(int idx, logic [31:0] d);
    @(negedge clk); bdWe = 1'b1; bdIdx = 10'(idx); bdData = d;
    @(negedge clk); bdWe = 1'b0;
  endtask

  task automatic setDesc(int slot, int src, int dst, int len, int last, logic [31:0] seed);
    memWr(slot * 4, 32'(src));
    memWr(slot * 4 + 1, (32'(len) << 16) | (32'(last) << 30));
    memWr(256 + slot * 4, 32'(dst));
    memWr(256 + slot * 4 + 1, seed);
  endtask

  task automatic waitDma(logic [31:0] exp, int maxCyc);
    logic [31:0] v;
    for (int i = 0; i < maxCyc; i++) begin
      regRd(12'h00C, v);
      if (v == exp) return;
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int src, dst, len, last, nw, wc;
    regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRd(12'h004, v); chk("R1 tx count", v, 32'd64);
    regRd(12'h104, v); chk("R1 rx count", v, 32'd64);
    regRd(12'h108, v); chk("R1 rx cpu idx", v, 32'd63);
    regRd(12'h00C, v); chk("R1 tx dma idx", v, 32'd0);
    regRd(12'h204, v); chk("R1 global", v, 32'd0);
    chk("R1 no request", 32'(memReqValid), 32'd0);

    for (int i = 512; i < 768; i++) memWr(i, SRC_PAT + 32'(i));
    regWr(12'h000, 32'h0000);
    regWr(12'h100, 32'h0400);
    regWr(12'h204, 32'h45);

    // vector table walk: R2, R3, R4, R5 (zero length)
    for (int k = 0; k < 4; k++) begin
      src = int'(VEC[k][63:48]); dst = int'(VEC[k][47:32]);
      len = int'(VEC[k][31:16]); last = int'(VEC[k][15:0]);
      nw = len / 4;
      for (int j = 0; j <= nw; j++) memWr(dst / 4 + j, 32'hDEAD0000 + 32'(j));
      setDesc(k, src, dst, len, last, 32'h0);
      regWr(12'h008, 32'(k + 1));
      waitDma(32'(k + 1), 2000);
      for (int j = 0; j < nw; j++)
        chk("R3 copied word", mem[dst / 4 + j], SRC_PAT + 32'(src / 4 + j));
      chk("R3 R5 word past length untouched", mem[dst / 4 + nw], 32'hDEAD0000 + 32'(nw));
      chk("R4 completion word", mem[256 + k * 4 + 1],
          (32'(len) << 16) | 32'h8000_0000 | (32'(last) << 30));
      regRd(12'h10C, v); chk("R2 rx dma idx advanced", v, 32'(k + 1));
    end

    // R4 write-back disabled
    regWr(12'h204, 32'h05);
    setDesc(4, 32'h900, 32'hD00, 8, 1, 32'h12345678);
    regWr(12'h008, 32'd5);
    waitDma(32'd5, 2000);
    chk("R3 copy without write-back", mem[32'hD00 / 4 + 1], SRC_PAT + 32'(32'h900 / 4 + 1));
    chk("R4 rx word1 untouched", mem[256 + 4 * 4 + 1], 32'h12345678);

    // R6 stop mid-slot
    regWr(12'h204, 32'h45);
    setDesc(5, 32'h900, 32'hE00, 256, 0, 32'h0);
    setDesc(6, 32'h800, 32'hF80, 4, 0, 32'h0);
    regWr(12'h008, 32'd7);
    repeat (20) @(negedge clk);
    regRd(12'h204, v); chk("R6 busy bits while running", v, 32'h4F);
    regWr(12'h204, 32'h40);
    for (int i = 0; i < 3000; i++) begin
      regRd(12'h204, v);
      if ((v & 32'h0A) == 32'h0) break;
    end
    chk("R6 write-back done before busy fell", mem[256 + 5 * 4 + 1], 32'h0100_0000 | 32'h8000_0000);
    chk("R6 slot finished", mem[32'hE00 / 4 + 63], SRC_PAT + 32'(32'h900 / 4 + 63));
    repeat (100) @(negedge clk);
    regRd(12'h00C, v); chk("R6 no new slot while disabled", v, 32'd6);
    regRd(12'h204, v); chk("R6 busy low", v, 32'h40);
    regWr(12'h204, 32'h45);
    waitDma(32'd7, 2000);
    chk("R2 resumes after re-enable", mem[32'hF80 / 4], SRC_PAT + 32'(512));

    // R7 reset register
    regWr(12'h204, 32'h0);
    regWr(12'h008, 32'd0);
    regWr(12'h208, 32'h1);
    regRd(12'h00C, v); chk("R7 tx dma cleared", v, 32'd0);
    regRd(12'h10C, v); chk("R7 rx dma kept", v, 32'd7);
    regWr(12'h208, 32'h10000);
    regRd(12'h10C, v); chk("R7 rx dma cleared", v, 32'd0);

    // R9 wrap with 4 slots
    regWr(12'h004, 32'd4);
    regWr(12'h104, 32'd4);
    for (int s = 0; s < 4; s++) setDesc(s, 32'h800 + s * 4, 32'hF00 + s * 4, 4, 1, 32'h0);
    regWr(12'h204, 32'h45);
    regWr(12'h008, 32'd3);
    waitDma(32'd3, 2000);
    regWr(12'h008, 32'd0);
    waitDma(32'd0, 2000);
    regRd(12'h10C, v); chk("R9 rx dma wrapped", v, 32'd0);
    chk("R9 last slot copied", mem[32'hF00 / 4 + 3], SRC_PAT + 32'(512 + 3));
    chk("R9 last slot completion", mem[256 + 3 * 4 + 1], 32'h0004_0000 | 32'hC000_0000);

    // R5 clamp of an oversize length
    setDesc(0, 32'h800, 32'hC00, 14'h3FFC, 0, 32'h0);
    wc = writeCount;
    regWr(12'h008, 32'd1);
    waitDma(32'd1, 60000);
    chk("R5 clamped write count", 32'(writeCount - wc), 32'd4065);
    chk("R5 original length written back", mem[256 + 1], 32'hBFFC_0000);

    chk("R8 handshake violations", 32'(protoErr), 32'd0);
    summary();
    $finish;
  end
endmodule